// File: doc/BRIEF.md
# System Control Register File

This block holds a small set of 32-bit processor control and status registers. Each register is reached by a 5-bit index over one write port and one read port. The block does more than store words. Each stored register has its own rule for which bits a write may change. Some bits are held fixed no matter what is written. Three alias indices let software set flag bits in a parent register without rewriting the rest of it.

Several indices hold no storage at all; their read values are built from module parameters, such as the core number, core count and cache line size. Writes to these indices are dropped. A write to the performance-control index with the value 7 produces a one-cycle statistics-reset pulse. Writes that change the translation context produce a one-cycle invalidate pulse. Any access to an index at or above a parameterised limit raises a one-cycle error flag, and that access has no effect.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the registers read as follows (default parameters):
  - index 0 (system control): 0x08C50058, where bit 27 is the fast-interrupt-unmaskable bit;
  - index 4 (program status): 0x00000010, which is user mode in bits 4:0;
  - index 5 (event mailbox): 1;
  - index 6 (TLB type): 1;
  - indices 1, 2 and 3: 0.
- R2: A write to index 1 (coprocessor access) stores only the bits in mask 0x80F00000: bit 31 and bits 23:20. All other bits read back as 0.
- R3: A write to index 2 (FP status/control) changes only the bits in mask 0xFFF7009F. All other bits keep their previous value.
- R4: A write to index 3 (FP exception) changes only bits 30:29 (mask 0x60000000). All other bits are kept.
- R5: A write to index 0 never changes bit 27; all other bits take the written value. The cycle after a write to index 0, `xlat_inval` is high for one cycle. The same pulse follows a write to index 4 that changes bits 4:0; a write to index 4 that leaves bits 4:0 unchanged gives no pulse.
- R6: Writes to indices 6 to 13 have no effect on their read values.
- R7: Index 10 reads as 0x80000000 OR CORE_ID. When MULTI_PROC is 0, bit 30 is also set.
- R8: Index 11 (cache type) reads with:
  - bits 31:29 = 0b100 and bits 15:14 = 0b11;
  - bits 3:0, 19:16, 23:20 and 27:24 each equal to log2(LINE_BYTES/4), giving 0x8444C004 for 64-byte lines.
  Index 12 reads 0x00200000. Index 13 reads (NUM_CORES-1) in bits 25:24.
- R9: Writing exactly 0x7 to index 14 makes `stat_reset` high for one cycle. Other values written to index 14, and any write to indices 15 and 16, give no pulse. Indices 14 to 16 read as 0.
- R10: Alias writes OR selected bits into a parent register:
  - index 17 ORs wr_data bit 27 into index 4;
  - index 18 ORs wr_data bit 27 into index 2;
  - index 19 ORs wr_data & 0x9F into index 2.
  Reads of index 18 return index 2 with bit 27 cleared. Reads of index 19 return index 2 with bits 0x9F cleared. Reads of index 17 return 0.
- R11: A write or read to an index at or above UNIMP_START (default 20) sets `err` high for one cycle. Such a write changes no register. Such a read returns 0.
- R12: `rd_data` is updated one cycle after `rd_en` and holds between reads. A read of the same index in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after an access to an unimplemented index |
| xlat_inval | output | 1 | One-cycle pulse to invalidate cached translation state |
| stat_reset | output | 1 | One-cycle pulse to reset statistics |

## Verification
The bench writes all ones to every masked register and checks the exact masked result. A design with a wrong mask would show stray bits, or would lose the non-writable bits it should keep. It writes both 0 and all ones to the system control register, which catches a design that lets bit 27 follow the written value. It writes the program status register twice with the same mode and checks for a pulse only on the first write, which catches a design that pulses on every write. It sends values one off from 0x7 and sends 0x7 to the neighbouring indices, which catches a loose statistics-reset decode. Out-of-range writes are followed by read-back of stored registers, which catches a design that flags the error but still writes. A read and a write to the same index in one cycle catches a design that forwards the new value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int IDX_W = 5;
  localparam int DW    = 32;

  // register index map
  localparam logic [IDX_W-1:0] IX_CTRL  = 5'd0;
  localparam logic [IDX_W-1:0] IX_ACC   = 5'd1;
  localparam logic [IDX_W-1:0] IX_FST   = 5'd2;
  localparam logic [IDX_W-1:0] IX_FEX   = 5'd3;
  localparam logic [IDX_W-1:0] IX_PST   = 5'd4;
  localparam logic [IDX_W-1:0] IX_MBX   = 5'd5;
  localparam logic [IDX_W-1:0] IX_TLBT  = 5'd6;
  localparam logic [IDX_W-1:0] IX_MAIN  = 5'd7;
  localparam logic [IDX_W-1:0] IX_FEAT0 = 5'd8;
  localparam logic [IDX_W-1:0] IX_FEAT1 = 5'd9;
  localparam logic [IDX_W-1:0] IX_MPID  = 5'd10;
  localparam logic [IDX_W-1:0] IX_CTYPE = 5'd11;
  localparam logic [IDX_W-1:0] IX_CLVL  = 5'd12;
  localparam logic [IDX_W-1:0] IX_L2CTL = 5'd13;
  localparam logic [IDX_W-1:0] IX_PMCTL = 5'd14;
  localparam logic [IDX_W-1:0] IX_PMCNT = 5'd15;
  localparam logic [IDX_W-1:0] IX_PMSEL = 5'd16;
  localparam logic [IDX_W-1:0] IX_SAT   = 5'd17;
  localparam logic [IDX_W-1:0] IX_FQC   = 5'd18;
  localparam logic [IDX_W-1:0] IX_FEXC  = 5'd19;

  // write masks
  localparam logic [DW-1:0] ACC_M  = 32'h80F0_0000;
  localparam logic [DW-1:0] FST_M  = 32'hFFF7_009F;
  localparam logic [DW-1:0] FEX_M  = 32'h6000_0000;
  localparam logic [DW-1:0] NMFI_M = 32'h0800_0000;
  localparam logic [DW-1:0] SAT_M  = 32'h0800_0000;
  localparam logic [DW-1:0] QC_M   = 32'h0800_0000;
  localparam logic [DW-1:0] EXC_M  = 32'h0000_009F;
  localparam logic [4:0]    MODE_USER = 5'h10;

  // reset / constant values
  localparam logic [DW-1:0] CTRL_BASE = 32'h00C5_0058;
  localparam logic [DW-1:0] FEAT0_VAL = 32'h1111_0222;
  localparam logic [DW-1:0] FEAT1_VAL = 32'h0111_1111;
  localparam logic [DW-1:0] CLVL_VAL  = 32'h0020_0000;
  localparam logic [DW-1:0] PM_GO     = 32'h0000_0007;

  typedef struct packed {
    logic [DW-1:0] ctrl;
    logic [DW-1:0] acc;
    logic [DW-1:0] fst;
    logic [DW-1:0] fex;
    logic [DW-1:0] pst;
    logic [DW-1:0] mbx;
  } regs_t;
endpackage

// File: rtl/sysctl_wr_path.sv
module sysctl_wr_path
  import sysctl_pkg::*;
(
  input  logic             wr_en,
  input  logic             wr_bad,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  regs_t            cur,
  output regs_t            nxt,
  output logic             inval_d,
  output logic             stat_d
);
  always_comb begin
    nxt     = cur;
    inval_d = 1'b0;
    stat_d  = 1'b0;
    if (wr_en && !wr_bad) begin
      case (wr_idx)
        IX_CTRL: begin
          nxt.ctrl = (wr_data & ~NMFI_M) | (cur.ctrl & NMFI_M);
          inval_d  = 1'b1;
        end
        IX_ACC:  nxt.acc = wr_data & ACC_M;
        IX_FST:  nxt.fst = (wr_data & FST_M) | (cur.fst & ~FST_M);
        IX_FEX:  nxt.fex = (wr_data & FEX_M) | (cur.fex & ~FEX_M);
        IX_PST: begin
          nxt.pst = wr_data;
          inval_d = (wr_data[4:0] != cur.pst[4:0]);
        end
        IX_MBX:  nxt.mbx = wr_data;
        IX_SAT:  nxt.pst = cur.pst | (wr_data & SAT_M);
        IX_FQC:  nxt.fst = cur.fst | (wr_data & QC_M);
        IX_FEXC: nxt.fst = cur.fst | (wr_data & EXC_M);
        IX_PMCTL: stat_d = (wr_data == PM_GO);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path
  import sysctl_pkg::*;
#(
  parameter int          CORE_ID    = 2,
  parameter int          NUM_CORES  = 4,
  parameter bit          MULTI_PROC = 1'b1,
  parameter int          LINE_BYTES = 64,
  parameter logic [31:0] MAIN_ID    = 32'h410F_C0F1
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  regs_t            cur,
  output logic [DW-1:0]    rd_val
);
  localparam int LW = $clog2(LINE_BYTES / 4);
  localparam logic [DW-1:0] LWV = DW'(LW);
  localparam logic [DW-1:0] CTYPE_VAL = 32'h8000_C000 | (LWV << 24) |
                                        (LWV << 20) | (LWV << 16) | LWV;
  localparam logic [DW-1:0] L2_VAL = DW'((NUM_CORES - 1) & 3) << 24;

  logic [DW-1:0] mpid_val;

  generate
    if (MULTI_PROC) begin : g_mp
      assign mpid_val = 32'h8000_0000 | DW'(CORE_ID);
    end else begin : g_up
      assign mpid_val = 32'hC000_0000 | DW'(CORE_ID);
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    case (rd_idx)
      IX_CTRL:  rd_val = cur.ctrl;
      IX_ACC:   rd_val = cur.acc;
      IX_FST:   rd_val = cur.fst;
      IX_FEX:   rd_val = cur.fex;
      IX_PST:   rd_val = cur.pst;
      IX_MBX:   rd_val = cur.mbx;
      IX_TLBT:  rd_val = 32'h1;
      IX_MAIN:  rd_val = MAIN_ID;
      IX_FEAT0: rd_val = FEAT0_VAL;
      IX_FEAT1: rd_val = FEAT1_VAL;
      IX_MPID:  rd_val = mpid_val;
      IX_CTYPE: rd_val = CTYPE_VAL;
      IX_CLVL:  rd_val = CLVL_VAL;
      IX_L2CTL: rd_val = L2_VAL;
      IX_FQC:   rd_val = cur.fst & ~QC_M;
      IX_FEXC:  rd_val = cur.fst & ~EXC_M;
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          CORE_ID     = 2,
  parameter int          NUM_CORES   = 4,
  parameter bit          MULTI_PROC  = 1'b1,
  parameter int          LINE_BYTES  = 64,
  parameter logic [31:0] MAIN_ID     = 32'h410F_C0F1,
  parameter bit          NMFI_RST    = 1'b1,
  parameter int          UNIMP_START = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             err,
  output logic             xlat_inval,
  output logic             stat_reset
);
  localparam logic [DW-1:0] CTRL_RST = CTRL_BASE | (NMFI_RST ? NMFI_M : '0);
  localparam regs_t REGS_RST = '{ctrl: CTRL_RST, acc: '0, fst: '0, fex: '0,
                                 pst: {27'd0, MODE_USER}, mbx: 32'h1};

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic wr_bad, rd_bad;
  assign wr_bad = (32'(wr_idx) >= 32'(UNIMP_START));
  assign rd_bad = (32'(rd_idx) >= 32'(UNIMP_START));

  regs_t         r_q, r_d;
  logic          inval_d, stat_d, err_d;
  logic [DW-1:0] rd_val, rd_d;

  sysctl_wr_path u_wr (
    .wr_en   (wr_en),
    .wr_bad  (wr_bad),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cur     (r_q),
    .nxt     (r_d),
    .inval_d (inval_d),
    .stat_d  (stat_d)
  );

  sysctl_rd_path #(
    .CORE_ID    (CORE_ID),
    .NUM_CORES  (NUM_CORES),
    .MULTI_PROC (MULTI_PROC),
    .LINE_BYTES (LINE_BYTES),
    .MAIN_ID    (MAIN_ID)
  ) u_rd (
    .rd_idx (rd_idx),
    .cur    (r_q),
    .rd_val (rd_val)
  );

  always_comb begin
    rd_d  = rd_bad ? '0 : rd_val;
    err_d = (wr_en && wr_bad) || (rd_en && rd_bad);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      r_q        <= REGS_RST;
      rd_data    <= '0;
      err        <= 1'b0;
      xlat_inval <= 1'b0;
      stat_reset <= 1'b0;
    end else begin
      if (wr_en) r_q <= r_d;
      if (rd_en) rd_data <= rd_d;
      err        <= err_d;
      xlat_inval <= inval_d;
      stat_reset <= stat_d;
    end
  end

  AST_ACC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (r_q.acc & ~ACC_M) == '0); // R2
  AST_FEX_KEEP: assert property (@(posedge clk) disable iff (!rst_sn)
    (r_q.fex & ~FEX_M) == ($past(r_q.fex) & ~FEX_M)); // R4
  AST_NMFI_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    $stable(r_q.ctrl[27])); // R5
  AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    xlat_inval |-> $past(wr_en && (wr_idx == IX_CTRL || wr_idx == IX_PST))); // R5
  AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    stat_reset |-> $past(wr_en && wr_idx == IX_PMCTL && wr_data == PM_GO)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    err |-> $past((wr_en && wr_bad) || (rd_en && rd_bad))); // R11
  AST_BAD_NOWRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(wr_en && wr_bad) |-> (r_q == $past(r_q))); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(!rd_en) |-> $stable(rd_data)); // R12
endmodule

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  wr_idx, rd_idx;
  logic [31:0] wr_data, rd_data;
  logic        err, xlat_inval, stat_reset;

  int checks = 0;
  int errors = 0;
  logic p_inval, p_stat, p_err;

  always #5 clk = ~clk;

  sysctl_regfile u_sysctl_regfile (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .err        (err),
    .xlat_inval (xlat_inval),
    .stat_reset (stat_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    p_inval = xlat_inval; p_stat = stat_reset; p_err = err;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] idx, output logic [31:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(posedge clk); #1;
    d = rd_data; e = err;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] idx, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    do_read(idx, d, e);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 5'd0, 32'h08C5_0058);
    rd_chk("R1 acc", 5'd1, 32'h0);
    rd_chk("R1 fst", 5'd2, 32'h0);
    rd_chk("R1 fex", 5'd3, 32'h0);
    rd_chk("R1 pst", 5'd4, 32'h10);
    rd_chk("R1 mbx", 5'd5, 32'h1);
    rd_chk("R1 tlbt", 5'd6, 32'h1);
  endtask

  task automatic t_access;
    do_write(5'd1, 32'hFFFF_FFFF);
    rd_chk("R2 all ones", 5'd1, 32'h80F0_0000);
    do_write(5'd1, 32'h0030_0001);
    rd_chk("R2 partial", 5'd1, 32'h0030_0000);
  endtask

  task automatic t_fstat;
    do_write(5'd2, 32'hFFFF_FFFF);
    rd_chk("R3 all ones", 5'd2, 32'hFFF7_009F);
    do_write(5'd2, 32'h0);
    rd_chk("R3 clear", 5'd2, 32'h0);
  endtask

  task automatic t_fexc;
    do_write(5'd3, 32'hFFFF_FFFF);
    rd_chk("R4 all ones", 5'd3, 32'h6000_0000);
    do_write(5'd3, 32'h9FFF_FFFF);
    rd_chk("R4 clear", 5'd3, 32'h0);
  endtask

  task automatic t_ctrl;
    do_write(5'd0, 32'h0);
    chk("R5 ctrl pulse", 32'(p_inval), 32'h1);
    rd_chk("R5 nmfi kept on zero", 5'd0, 32'h0800_0000);
    do_write(5'd0, 32'hF7FF_FFFF);
    rd_chk("R5 nmfi kept on ones", 5'd0, 32'hFFFF_FFFF);
    do_write(5'd4, 32'h0000_0013);
    chk("R5 mode change pulse", 32'(p_inval), 32'h1);
    do_write(5'd4, 32'h0000_0013);
    chk("R5 same mode no pulse", 32'(p_inval), 32'h0);
    do_write(5'd5, 32'h0);
    chk("R5 other reg no pulse", 32'(p_inval), 32'h0);
  endtask

  task automatic t_ident;
    for (int i = 6; i <= 13; i++) do_write(5'(i), 32'hFFFF_FFFF);
    rd_chk("R6 tlbt", 5'd6, 32'h1);
    rd_chk("R6 main id", 5'd7, 32'h410F_C0F1);
    rd_chk("R6 feat0", 5'd8, 32'h1111_0222);
    rd_chk("R6 feat1", 5'd9, 32'h0111_1111);
    rd_chk("R7 mpid", 5'd10, 32'h8000_0002);
    rd_chk("R8 cache type", 5'd11, 32'h8444_C004);
    rd_chk("R8 cache level", 5'd12, 32'h0020_0000);
    rd_chk("R8 l2 count", 5'd13, 32'h0300_0000);
  endtask

  task automatic t_pm;
    do_write(5'd14, 32'h7);
    chk("R9 go pulse", 32'(p_stat), 32'h1);
    do_write(5'd14, 32'h6);
    chk("R9 value 6", 32'(p_stat), 32'h0);
    do_write(5'd14, 32'h1_0007);
    chk("R9 wide value", 32'(p_stat), 32'h0);
    do_write(5'd15, 32'h7);
    chk("R9 counter idx", 32'(p_stat), 32'h0);
    do_write(5'd16, 32'h7);
    chk("R9 select idx", 32'(p_stat), 32'h0);
    rd_chk("R9 read zero", 5'd14, 32'h0);
  endtask

  task automatic t_alias;
    do_write(5'd4, 32'h10);
    do_write(5'd17, 32'hFFFF_FFFF);
    rd_chk("R10 sat into pst", 5'd4, 32'h0800_0010);
    rd_chk("R10 sat read", 5'd17, 32'h0);
    do_write(5'd2, 32'h0040_0000);
    do_write(5'd18, 32'hFFFF_FFFF);
    rd_chk("R10 qc into fst", 5'd2, 32'h0840_0000);
    do_write(5'd19, 32'hFFFF_FFFF);
    rd_chk("R10 exc into fst", 5'd2, 32'h0840_009F);
    rd_chk("R10 qc alias read", 5'd18, 32'h0040_009F);
    rd_chk("R10 exc alias read", 5'd19, 32'h0840_0000);
  endtask

  task automatic t_unimp;
    logic [31:0] d;
    logic e;
    do_write(5'd5, 32'h1234_5678);
    chk("R11 legal no err", 32'(p_err), 32'h0);
    do_write(5'd20, 32'hDEAD_BEEF);
    chk("R11 write err", 32'(p_err), 32'h1);
    do_write(5'd31, 32'hFFFF_FFFF);
    chk("R11 write err top", 32'(p_err), 32'h1);
    rd_chk("R11 mbx intact", 5'd5, 32'h1234_5678);
    rd_chk("R11 ctrl intact", 5'd0, 32'hFFFF_FFFF);
    do_read(5'd25, d, e);
    chk("R11 read data", d, 32'h0);
    chk("R11 read err", 32'(e), 32'h1);
    @(posedge clk); #1;
    chk("R11 err one cycle", 32'(err), 32'h0);
  endtask

  task automatic t_rdtiming;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'hCAFE_0001;
    rd_en = 1'b1; rd_idx = 5'd5;
    @(posedge clk); #1;
    chk("R12 same cycle old", rd_data, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R12 hold", rd_data, 32'h1234_5678);
    rd_chk("R12 new value", 5'd5, 32'hCAFE_0001);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_idx = '0; rd_idx = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_access();
    t_fstat();
    t_fexc();
    t_ctrl();
    t_ident();
    t_pm();
    t_alias();
    t_unimp();
    t_rdtiming();
    finish_run();
  end
endmodule